// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block is a memory-mapped timer with a parameterized number of identical 32-bit channels (three by default). One 8-bit run register is shared by all channels, one bit per channel. Each channel has a reload value, a live down-counter and a 16-bit control register. A running channel decrements on the tick picked by its prescaler code. When the count is zero, the next tick reloads the count from the reload value and sets a sticky underflow flag. The channel's interrupt output is the flag gated by the channel's interrupt enable.

Software uses a channel in one of two ways. As a free-running clocksource, it loads both counter and reload value with all ones and reads the elapsed ticks as the count XOR 0xFFFFFFFF. As an event source, it writes the counter for the first interval and the reload value for the period. Writes are synchronous on a simple request/write-enable port with byte, halfword and word sizes. Reads are combinational from the address and have no side effects.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the run register and all control registers read 0, every counter and reload value reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: Bit n of the run register (word offset 0x00, bits 7:0, all eight readable) runs channel n when 1. A channel whose bit is 0 holds its count. While the channel is stopped, its counter and reload value still accept writes.
- R3: A running channel with a nonzero count decrements by exactly one on each selected tick. Software therefore sees elapsed ticks as the count XOR 0xFFFFFFFF after starting from 0xFFFFFFFF.
- R4: On the first selected tick with the count at zero, the counter loads the reload value and the flag is set. A reload value of N therefore gives a period of N+1 ticks.
- R5: Control bits 2:0 select the tick: 0 gives clock/4, 1 gives clock/16, 2 gives clock/64, 3 gives clock/256, and any other code behaves as clock/4. The prescaler runs freely and is shared by all channels.
- R6: The underflow flag is control bit 8 and is sticky. It clears only on a control write whose byte lane 1 is enabled with bit 8 equal to 0. A write with bit 8 equal to 1, or a write that does not enable lane 1, leaves the flag as it is. An underflow in the same cycle as a clearing write wins.
- R7: Control bit 5 enables the interrupt. irq_o[n] is high exactly when channel n's flag and enable are both 1.
- R8: size_i selects the access width: 0 is byte, 1 is halfword, 2 or 3 is word. Byte lane k carries wdata_i[8k+7:8k]. A byte access writes lane addr_i[1:0] only. A halfword access writes lanes 2*addr_i[1] and 2*addr_i[1]+1. No other bits of the target register change.
- R9: Channel n's reload value is at 4+12n, its counter at 8+12n and its control at 12+12n. Control bits other than 8, 5 and 2:0 read 0. Any address past the last channel reads 0.
- R10: Running, writing or underflowing one channel leaves every other channel's count, reload value, control and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| size_i | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data, lane-aligned |
| rdata_o | output | 32 | Combinational read data of the addressed word |
| irq_o | output | 3 | Per-channel level interrupt |

## Verification
The assertions check the per-edge rules on every cycle:
- a stopped channel freezes its count;
- a nonzero count drops by one per selected tick;
- a zero count reloads and flags on the next tick;
- the flag stays set until a clearing write;
- an interrupt never rises without an underflow or a control write;
- the prescaler ticks nest;
- the run register changes only on a write to word 0.

Only the bench scenarios can show the things that depend on what the bus observes:
- the tick rate of each prescaler code, measured over exact 256-cycle windows;
- the reset contents and the address map;
- byte-lane merging;
- periodic reload seen through reads;
- the acknowledge sequence;
- the independence of channels while another one runs and underflows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NDIV        = 4;   // prescaler taps: /4 /16 /64 /256
  localparam int CTRL_W      = 16;
  localparam int IE_BIT      = 5;
  localparam int FLAG_BIT    = 8;
  localparam int PSC_W       = 3;

  typedef enum logic [PSC_W-1:0] {
    PSC_D4   = 3'd0,
    PSC_D16  = 3'd1,
    PSC_D64  = 3'd2,
    PSC_D256 = 3'd3
  } psc_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int TAPS = NDIV
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TAPS-1:0] tick_o
);
  localparam int CW = 2 * TAPS;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // tap k fires once every 4^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tick_o[k] = &cnt_q[2*k+1:0];
    if (k > 0) begin : g_nest
      a_r5_tick_nest : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[k] |-> tick_o[k-1]);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW   = 32,
  parameter int TAPS = NDIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [TAPS-1:0]   tick_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic [CW/8-1:0]   be_i,
  input  logic              we_const_i,
  input  logic              we_cnt_i,
  input  logic              we_ctrl_i,
  output logic [CW-1:0]     const_o,
  output logic [CW-1:0]     cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  localparam int NB = CW / 8;

  logic [CW-1:0]    const_q, cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             ie_q, flag_q;
  logic             tick_sel, underflow, flag_clr;

  function automatic logic [CW-1:0] merge(input logic [CW-1:0] old_v,
                                          input logic [CW-1:0] new_v,
                                          input logic [NB-1:0] be);
    logic [CW-1:0] r;
    r = old_v;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction

  always_comb begin
    unique case (psc_q)
      PSC_D16:  tick_sel = tick_i[1];
      PSC_D64:  tick_sel = tick_i[2];
      PSC_D256: tick_sel = tick_i[3];
      default:  tick_sel = tick_i[0];
    endcase
  end

  assign underflow = run_i && tick_sel && (cnt_q == '0) && !we_cnt_i;
  assign flag_clr  = we_ctrl_i && be_i[1] && !wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      const_q <= '1;
      cnt_q   <= '1;
      psc_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (we_const_i) const_q <= merge(const_q, wdata_i, be_i);
      // bus write beats the tick in the same cycle
      if (we_cnt_i)                 cnt_q <= merge(cnt_q, wdata_i, be_i);
      else if (run_i && tick_sel)   cnt_q <= (cnt_q == '0) ? const_q : cnt_q - 1'b1;
      if (we_ctrl_i && be_i[0]) begin
        psc_q <= wdata_i[PSC_W-1:0];
        ie_q  <= wdata_i[IE_BIT];
      end
      // set wins over clear so no event is lost
      if (underflow)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[PSC_W-1:0] = psc_q;
    ctrl_o[IE_BIT]   = ie_q;
    ctrl_o[FLAG_BIT] = flag_q;
  end

  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign irq_o   = flag_q && ie_q;

  a_r2_stopped_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_cnt_i) |=> $stable(cnt_q));
  a_r3_dec_by_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_sel && cnt_q != '0 && !we_cnt_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r4_reload_flag : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_sel && cnt_q == '0 && !we_cnt_i) |=> (cnt_q == $past(const_q)) && flag_q);
  a_r6_flag_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);
  a_r7_irq_cause : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !we_ctrl_i && !underflow) |=> !irq_o);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int CW      = 32,
  parameter int AW      = 6,
  parameter int START_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [1:0]     size_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o
);
  localparam int NB   = CW / 8;
  localparam int WA_W = AW - 2;

  logic [WA_W-1:0]    waddr;
  logic [NB-1:0]      be;
  logic               wr;
  logic [START_W-1:0] start_q;
  logic [NDIV-1:0]    tick;

  logic [NCH-1:0]        sel_const, sel_cnt, sel_ctrl;
  logic [CW-1:0]         const_v [NCH];
  logic [CW-1:0]         cnt_v   [NCH];
  logic [CTRL_W-1:0]     ctrl_v  [NCH];

  assign waddr = addr_i[AW-1:2];
  assign wr    = req_i && we_i;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: be = NB'(1) << addr_i[1:0];
      SZ_HALF: be = NB'(3) << {addr_i[1], 1'b0};
      default: be = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          start_q <= '0;
    else if (wr && waddr == '0 && be[0])  start_q <= wdata_i[START_W-1:0];
  end

  tmr_prescaler #(.TAPS(NDIV)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign sel_const[n] = (waddr == WA_W'(1 + 3*n));
    assign sel_cnt[n]   = (waddr == WA_W'(2 + 3*n));
    assign sel_ctrl[n]  = (waddr == WA_W'(3 + 3*n));

    tmr_channel #(.CW(CW), .TAPS(NDIV)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (start_q[n]),
      .tick_i     (tick),
      .wdata_i    (wdata_i),
      .be_i       (be),
      .we_const_i (wr && sel_const[n]),
      .we_cnt_i   (wr && sel_cnt[n]),
      .we_ctrl_i  (wr && sel_ctrl[n]),
      .const_o    (const_v[n]),
      .cnt_o      (cnt_v[n]),
      .ctrl_o     (ctrl_v[n]),
      .irq_o      (irq_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (waddr == '0) rdata_o = CW'(start_q);
    for (int n = 0; n < NCH; n++) begin
      if (sel_const[n]) rdata_o = const_v[n];
      if (sel_cnt[n])   rdata_o = cnt_v[n];
      if (sel_ctrl[n])  rdata_o = CW'(ctrl_v[n]);
    end
  end

  a_r2_start_write_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && waddr == '0) |=> $stable(start_q));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd2;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int checks = 0, errors = 0;
  logic [31:0] rv, a, b;

  always #(CLK_P/2) clk = ~clk;

  tmr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] a_const(input int n); return 6'(4 + 12*n);  endfunction
  function automatic logic [5:0] a_cnt(input int n);   return 6'(8 + 12*n);  endfunction
  function automatic logic [5:0] a_ctrl(input int n);  return 6'(12 + 12*n); endfunction

  task automatic chk(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req_tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [5:0] ad, input logic [1:0] sz, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = ad; size = sz; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] ad, output logic [31:0] d);
    addr = ad; #1; d = rdata;
  endtask

  task automatic set_run(input int n, input bit on);
    logic [31:0] s;
    rd(6'd0, s);
    if (on) s[n] = 1'b1; else s[n] = 1'b0;
    wr(6'd0, 2'd0, s);
  endtask

  task automatic t_reset;
    rd(6'd0, rv); chk("R1 run reg", rv, 0);
    for (int n = 0; n < 3; n++) begin
      rd(a_const(n), rv); chk("R1 reload", rv, 32'hFFFF_FFFF);
      rd(a_cnt(n), rv);   chk("R1 count", rv, 32'hFFFF_FFFF);
      rd(a_ctrl(n), rv);  chk("R1 ctrl", rv, 0);
    end
    chk("R1 irq", {29'd0, irq}, 0);
  endtask

  task automatic t_map;
    wr(a_ctrl(2), 2'd2, 32'hFFFF_FFFF);
    rd(a_ctrl(2), rv); chk("R9 ctrl mask", rv, 32'h0000_0027);
    wr(a_ctrl(2), 2'd2, 32'h0);
    rd(6'h28, rv); chk("R9 unmapped", rv, 0);
    wr(6'd0, 2'd0, 32'h0000_00F8);
    rd(6'd0, rv); chk("R2 run reg 8 bits", rv, 32'hF8);
    wr(6'd0, 2'd0, 32'h0);
  endtask

  task automatic t_lanes;
    wr(a_const(2), 2'd2, 32'h1122_3344);
    wr(a_const(2) + 6'd2, 2'd0, 32'h00AA_0000);
    rd(a_const(2), rv); chk("R8 byte lane", rv, 32'h11AA_3344);
    wr(a_const(2) + 6'd2, 2'd1, 32'hBEEF_0000);
    rd(a_const(2), rv); chk("R8 halfword", rv, 32'hBEEF_3344);
    wr(a_const(2), 2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_free_run;
    set_run(0, 1'b1);
    rd(a_cnt(0), a);
    repeat (40) @(negedge clk);
    rd(a_cnt(0), b);
    chk("R3 elapsed ticks", (b ^ 32'hFFFF_FFFF) - (a ^ 32'hFFFF_FFFF), 32'd10);
  endtask

  task automatic t_hold;
    set_run(0, 1'b0);
    rd(a_cnt(0), a);
    repeat (50) @(negedge clk);
    rd(a_cnt(0), b); chk("R2 stopped holds", b, a);
    wr(a_cnt(0), 2'd2, 32'h100);
    rd(a_cnt(0), rv); chk("R2 write while stopped", rv, 32'h100);
  endtask

  task automatic t_underflow;
    wr(a_const(1), 2'd2, 32'd5);
    wr(a_cnt(1), 2'd2, 32'd1);
    wr(a_ctrl(1), 2'd2, 32'h20);
    set_run(1, 1'b1);
    repeat (12) @(negedge clk);        // three /4 ticks: 1,0,5,4
    rd(a_cnt(1), rv);  chk("R4 reload count", rv, 32'd4);
    rd(a_ctrl(1), rv); chk("R4 flag set", rv, 32'h120);
    chk("R7 irq up", {29'd0, irq}, 32'b010);
    wr(a_ctrl(1), 2'd2, 32'h20);       // acknowledge
    rd(a_ctrl(1), rv); chk("R6 ack clears", rv, 32'h20);
    chk("R7 irq down", {29'd0, irq}, 0);
    repeat (23) @(negedge clk);        // 24 edges since the ack edge: 6 ticks
    rd(a_cnt(1), rv);  chk("R4 periodic count", rv, 32'd4);
    rd(a_ctrl(1), rv); chk("R4 periodic flag", rv, 32'h120);
    rd(a_cnt(0), rv);  chk("R10 ch0 untouched", rv, 32'h100);
    rd(a_cnt(2), rv);  chk("R10 ch2 untouched", rv, 32'hFFFF_FFFF);
    rd(a_ctrl(2), rv); chk("R10 ch2 ctrl", rv, 0);
    chk("R10 other irqs", {29'd0, irq & 3'b101}, 0);
  endtask

  task automatic t_flag;
    set_run(1, 1'b0);
    wr(a_ctrl(1), 2'd2, 32'h120);
    rd(a_ctrl(1), rv); chk("R6 write 1 keeps flag", rv, 32'h120);
    wr(a_ctrl(1), 2'd0, 32'h00);
    rd(a_ctrl(1), rv); chk("R6 lane0 write keeps flag", rv, 32'h100);
    chk("R7 irq gated by enable", {29'd0, irq}, 0);
    wr(a_ctrl(1), 2'd0, 32'h20);
    chk("R7 enable raises irq", {29'd0, irq}, 32'b010);
    wr(a_ctrl(1), 2'd1, 32'h0);
    rd(a_ctrl(1), rv); chk("R6 zero write clears", rv, 0);
    chk("R7 irq after clear", {29'd0, irq}, 0);
  endtask

  task automatic t_psc;
    logic [2:0]  code [4] = '{3'd1, 3'd2, 3'd3, 3'd7};
    logic [31:0] exp  [4] = '{32'd16, 32'd4, 32'd1, 32'd64};
    set_run(2, 1'b1);
    for (int i = 0; i < 4; i++) begin
      wr(a_ctrl(2), 2'd2, {29'd0, code[i]});
      rd(a_cnt(2), a);
      repeat (256) @(negedge clk);
      rd(a_cnt(2), b);
      chk("R5 prescaler rate", a - b, exp[i]);
    end
    set_run(2, 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_lanes;
    t_free_run;
    t_hold;
    t_underflow;
    t_flag;
    t_psc;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule